// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch and Status Controller

This block sits between a CPU register interface and the command engine of an on-chip nonvolatile memory. Software loads an opcode and a target address into staging registers. It then writes 1 to the completion flag of the status byte to start the command. Before anything reaches the engine, the block checks the opcode against the legal set and checks program and erase targets against a protected address window. A rejected command completes at once with a sticky error flag. An accepted command is handed to the engine with a one-cycle start pulse and finishes when the engine returns a one-cycle done pulse with a two-bit result.

The status byte reports the completion flag, two sticky error flags that are cleared by writing 1, a busy bit that follows the engine, and the latched engine result. While either error flag is set, no command can be launched. Three interrupt requests are gated by enable bits: one for command completion, and one each for the single-bit and double-bit read faults reported by the ECC decoder.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80, the configuration register reads 0x00, the window-low register reads all ones, the window-high register reads 0, and the start pulse and all interrupt requests are 0.
- R2: Register map on the 3-bit bus address: 0 = status, 1 = configuration (bit 7 completion interrupt enable, bit 1 double-fault enable, bit 0 single-fault enable, other bits read 0), 2 = opcode and 3 = target address (both write-only, read 0), 4 = window low, 5 = window high (readable). Status byte: bit 7 completion flag, bit 5 access error, bit 4 protection violation, bit 3 busy, bits 1:0 engine result; bits 6 and 2 read 0.
- R3: A write of 1 to status bit 7 launches a command when the completion flag is 1 and both error flags are 0. For a legal, unprotected command, the completion flag reads 0 and the start pulse is high for exactly the one cycle after the write, with the staged opcode and address on the engine outputs. Busy reads 1 from that cycle until the command completes.
- R4: In the cycle after an engine done pulse, the engine result is latched into status bits 1:0, the completion flag reads 1 and busy reads 0.
- R5: The legal opcodes are 0x01 (read-verify), 0x06 (program), 0x08 (mass erase) and 0x0A (sector erase). Launching any other opcode sets the access-error flag and clears the completion flag for one cycle without a start pulse.
- R6: Program and sector erase whose target lies in the window (low <= address <= high, inclusive) set the protection-violation flag, and mass erase does so whenever low <= high. Read-verify is never checked. A protection hit completes after one cycle without a start pulse.
- R7: Writing 1 to status bit 5 or bit 4 clears that error flag. Writing 0 leaves it unchanged.
- R8: While either error flag is set, a write of 1 to status bit 7 neither clears the completion flag nor launches. While the protection-violation flag is set, writes to the opcode and target-address registers are ignored.
- R9: A write to the opcode or target-address register while the completion flag is 0 is ignored and sets the access-error flag.
- R10: Writes to the busy bit and the result bits have no effect.
- R11: The completion interrupt is 1 exactly when the completion flag is 1 and its enable is 1.
- R12: Each fault interrupt is 1 exactly when its fault input is 1 and its enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| sgl_fault_i | input | 1 | Single-bit read fault flag from the ECC decoder |
| dbl_fault_i | input | 1 | Double-bit read fault flag from the ECC decoder |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_cmd_o | output | 8 | Staged opcode |
| eng_addr_o | output | ADDR_W | Staged target address |
| eng_done_i | input | 1 | One-cycle completion pulse from the engine |
| eng_status_i | input | 2 | Engine result, valid with eng_done_i |
| irq_cc_o | output | 1 | Command-complete interrupt request |
| irq_sgl_o | output | 1 | Single-bit fault interrupt request |
| irq_dbl_o | output | 1 | Double-bit fault interrupt request |

## Verification
The bench builds the block with ADDR_W = 8, so the window registers and target addresses span the whole byte. This lets the window edges be probed one address inside and one address outside. The engine is modelled by directed done pulses with chosen result codes, so the latched result can be told apart from the previous one. Rejections by opcode, by window and by sticky flag are each followed by a legal launch, which proves that the flags and staging registers hold the values the requirements give.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
  localparam logic [7:0] OP_RDVFY  = 8'h01;
  localparam logic [7:0] OP_PROG   = 8'h06;
  localparam logic [7:0] OP_MERASE = 8'h08;
  localparam logic [7:0] OP_SERASE = 8'h0A;

  localparam int unsigned BUS_AW = 3;
  localparam logic [BUS_AW-1:0] REG_STAT  = 3'd0;
  localparam logic [BUS_AW-1:0] REG_CFG   = 3'd1;
  localparam logic [BUS_AW-1:0] REG_OPC   = 3'd2;
  localparam logic [BUS_AW-1:0] REG_TADDR = 3'd3;
  localparam logic [BUS_AW-1:0] REG_WLO   = 3'd4;
  localparam logic [BUS_AW-1:0] REG_WHI   = 3'd5;

  localparam int unsigned B_CCIF  = 7;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_PV    = 4;
  localparam int unsigned B_CC_IE = 7;
  localparam int unsigned B_DB_IE = 1;
  localparam int unsigned B_SB_IE = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_TERM, ST_START, ST_RUN} seq_state_e;
endpackage

// File: rtl/nvm_cmd_check.sv
module nvm_cmd_check
  import nvm_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] win_lo_i,
  input  logic [ADDR_W-1:0] win_hi_i,
  output logic              legal_o,
  output logic              prot_hit_o
);
  logic win_valid, in_win, is_pe;

  always_comb begin
    legal_o   = (opcode_i == OP_RDVFY) || (opcode_i == OP_PROG) ||
                (opcode_i == OP_MERASE) || (opcode_i == OP_SERASE);
    is_pe     = (opcode_i == OP_PROG) || (opcode_i == OP_SERASE);
    win_valid = (win_lo_i <= win_hi_i);
    in_win    = (addr_i >= win_lo_i) && (addr_i <= win_hi_i);
    // mass erase covers every address, so any non-empty window blocks it
    prot_hit_o = (is_pe && in_win) || ((opcode_i == OP_MERASE) && win_valid);
  end
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_req_i,
  input  logic       acc_clr_i,
  input  logic       pv_clr_i,
  input  logic       stage_wr_i,
  input  logic       legal_i,
  input  logic       prot_hit_i,
  input  logic       eng_done_i,
  input  logic [1:0] eng_status_i,
  output logic       ccif_o,
  output logic       accerr_o,
  output logic       pviol_o,
  output logic       busy_o,
  output logic [1:0] stat_o,
  output logic       start_o,
  output logic       stage_en_o
);
  seq_state_e state_q;
  logic       ccif_q, accerr_q, pviol_q;
  logic [1:0] stat_q;
  logic       launch_ok;

  // flags are taken before the write so a combined clear+launch does not launch
  assign launch_ok  = launch_req_i && ccif_q && !accerr_q && !pviol_q;
  assign stage_en_o = stage_wr_i && ccif_q && !pviol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ccif_q   <= 1'b1;
      accerr_q <= 1'b0;
      pviol_q  <= 1'b0;
      stat_q   <= '0;
    end else begin
      if (acc_clr_i) accerr_q <= 1'b0;
      if (pv_clr_i)  pviol_q  <= 1'b0;
      if (stage_wr_i && !ccif_q) accerr_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (launch_ok) begin
          ccif_q <= 1'b0;
          if (!legal_i) begin
            accerr_q <= 1'b1;
            state_q  <= ST_TERM;
          end else if (prot_hit_i) begin
            pviol_q <= 1'b1;
            state_q <= ST_TERM;
          end else begin
            state_q <= ST_START;
          end
        end
        ST_TERM: begin
          ccif_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_START: state_q <= ST_RUN;
        ST_RUN: if (eng_done_i) begin
          stat_q  <= eng_status_i;
          ccif_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ccif_o   = ccif_q;
  assign accerr_o = accerr_q;
  assign pviol_o  = pviol_q;
  assign stat_o   = stat_q;
  assign start_o  = (state_q == ST_START);
  assign busy_o   = (state_q == ST_START) || (state_q == ST_RUN);
endmodule

// File: rtl/nvm_cmd_irq.sv
module nvm_cmd_irq (
  input  logic ccif_i,
  input  logic cc_ie_i,
  input  logic sb_ie_i,
  input  logic db_ie_i,
  input  logic sgl_fault_i,
  input  logic dbl_fault_i,
  output logic irq_cc_o,
  output logic irq_sgl_o,
  output logic irq_dbl_o
);
  assign irq_cc_o  = ccif_i && cc_ie_i;
  assign irq_sgl_o = sgl_fault_i && sb_ie_i;
  assign irq_dbl_o = dbl_fault_i && db_ie_i;
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              sgl_fault_i,
  input  logic              dbl_fault_i,
  output logic              eng_start_o,
  output logic [7:0]        eng_cmd_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  input  logic              eng_done_i,
  input  logic [1:0]        eng_status_i,
  output logic              irq_cc_o,
  output logic              irq_sgl_o,
  output logic              irq_dbl_o
);
  logic [7:0]        opc_q;
  logic [ADDR_W-1:0] taddr_q, win_lo_q, win_hi_q;
  logic              cc_ie_q, sb_ie_q, db_ie_q;
  logic              wr_stat, stage_wr, stage_en;
  logic              legal, prot_hit;
  logic              ccif, accerr, pviol, busy;
  logic [1:0]        stat;

  assign wr_stat  = bus_we_i && (bus_addr_i == REG_STAT);
  assign stage_wr = bus_we_i && ((bus_addr_i == REG_OPC) || (bus_addr_i == REG_TADDR));

  nvm_cmd_check #(.ADDR_W(ADDR_W)) u_check (
    .opcode_i   (opc_q),
    .addr_i     (taddr_q),
    .win_lo_i   (win_lo_q),
    .win_hi_i   (win_hi_q),
    .legal_o    (legal),
    .prot_hit_o (prot_hit)
  );

  nvm_cmd_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_req_i (wr_stat && bus_wdata_i[B_CCIF]),
    .acc_clr_i    (wr_stat && bus_wdata_i[B_ACC]),
    .pv_clr_i     (wr_stat && bus_wdata_i[B_PV]),
    .stage_wr_i   (stage_wr),
    .legal_i      (legal),
    .prot_hit_i   (prot_hit),
    .eng_done_i   (eng_done_i),
    .eng_status_i (eng_status_i),
    .ccif_o       (ccif),
    .accerr_o     (accerr),
    .pviol_o      (pviol),
    .busy_o       (busy),
    .stat_o       (stat),
    .start_o      (eng_start_o),
    .stage_en_o   (stage_en)
  );

  nvm_cmd_irq u_irq (
    .ccif_i      (ccif),
    .cc_ie_i     (cc_ie_q),
    .sb_ie_i     (sb_ie_q),
    .db_ie_i     (db_ie_q),
    .sgl_fault_i (sgl_fault_i),
    .dbl_fault_i (dbl_fault_i),
    .irq_cc_o    (irq_cc_o),
    .irq_sgl_o   (irq_sgl_o),
    .irq_dbl_o   (irq_dbl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q    <= '0;
      taddr_q  <= '0;
      win_lo_q <= '1;
      win_hi_q <= '0;
      cc_ie_q  <= 1'b0;
      sb_ie_q  <= 1'b0;
      db_ie_q  <= 1'b0;
    end else begin
      if (stage_en && (bus_addr_i == REG_OPC))   opc_q   <= bus_wdata_i;
      if (stage_en && (bus_addr_i == REG_TADDR)) taddr_q <= bus_wdata_i[ADDR_W-1:0];
      if (bus_we_i && (bus_addr_i == REG_WLO)) win_lo_q <= bus_wdata_i[ADDR_W-1:0];
      if (bus_we_i && (bus_addr_i == REG_WHI)) win_hi_q <= bus_wdata_i[ADDR_W-1:0];
      if (bus_we_i && (bus_addr_i == REG_CFG)) begin
        cc_ie_q <= bus_wdata_i[B_CC_IE];
        db_ie_q <= bus_wdata_i[B_DB_IE];
        sb_ie_q <= bus_wdata_i[B_SB_IE];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_STAT: bus_rdata_o = {ccif, 1'b0, accerr, pviol, busy, 1'b0, stat};
      REG_CFG:  bus_rdata_o = {cc_ie_q, 5'b0, db_ie_q, sb_ie_q};
      REG_WLO:  bus_rdata_o[ADDR_W-1:0] = win_lo_q;
      REG_WHI:  bus_rdata_o[ADDR_W-1:0] = win_hi_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign eng_cmd_o  = opc_q;
  assign eng_addr_o = taddr_q;
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_we_i,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic       eng_start_o,
  input logic       eng_done_i,
  input logic       irq_cc_o,
  input logic       ccif,
  input logic       accerr,
  input logic       pviol,
  input logic       busy
);
  logic wr_stat;
  assign wr_stat = bus_we_i && (bus_addr_i == 3'd0);

  p_busy_not_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !ccif);

  p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_done_completes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !eng_start_o && eng_done_i) |=> (ccif && !busy));

  p_reject_no_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ccif) && $rose(accerr)) |=> (ccif && !eng_start_o));

  p_acc_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accerr && !(wr_stat && bus_wdata_i[5])) |=> accerr);

  p_pv_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pviol && !(wr_stat && bus_wdata_i[4])) |=> pviol);

  p_launch_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ccif) |-> (!$past(accerr) && !$past(pviol)));

  p_irq_cc_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ccif |-> !irq_cc_o);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .eng_start_o (eng_start_o),
  .eng_done_i  (eng_done_i),
  .irq_cc_o    (irq_cc_o),
  .ccif        (ccif),
  .accerr      (accerr),
  .pviol       (pviol),
  .busy        (busy)
);

// File: tb/sim_nvm_cmd_ctrl.sv
module sim_nvm_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic              clk, rst_n;
  logic              bus_we;
  logic [2:0]        bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic              sgl_fault, dbl_fault;
  logic              eng_start, eng_done;
  logic [7:0]        eng_cmd;
  logic [ADDR_W-1:0] eng_addr;
  logic [1:0]        eng_status;
  logic              irq_cc, irq_sgl, irq_dbl;

  int checks = 0;
  int errors = 0;
  logic [1:0] last_stat = 2'b00;

  nvm_cmd_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .sgl_fault_i(sgl_fault),
    .dbl_fault_i(dbl_fault), .eng_start_o(eng_start), .eng_cmd_o(eng_cmd),
    .eng_addr_o(eng_addr), .eng_done_i(eng_done), .eng_status_i(eng_status),
    .irq_cc_o(irq_cc), .irq_sgl_o(irq_sgl), .irq_dbl_o(irq_dbl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 3'd0;
  endtask

  function automatic logic [7:0] sbyte(input logic cc, input logic acc, input logic pv,
                                       input logic bsy, input logic [1:0] st);
    return {cc, 1'b0, acc, pv, bsy, 1'b0, st};
  endfunction

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(3'd0, v);
    chk(tag, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic eng_finish(input logic [1:0] s);
    eng_status = s; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_status = 2'b00;
    last_stat = s;
  endtask

  task automatic stage(input logic [7:0] op, input logic [7:0] ad);
    wr(3'd2, op);
    wr(3'd3, ad);
  endtask

  // legal, unprotected command: start pulse in the cycle after the launch write
  task automatic run_ok(input string tag, input logic [7:0] op, input logic [7:0] ad,
                        input logic [1:0] res);
    stage(op, ad);
    wr(3'd0, 8'h80);
    chk({tag, " start"}, {31'd0, eng_start}, 32'd1);
    chk({tag, " cmd"}, {24'd0, eng_cmd}, {24'd0, op});
    chk({tag, " addr"}, {24'd0, eng_addr}, {24'd0, ad});
    chk_stat({tag, " busy"}, sbyte(1'b0, 1'b0, 1'b0, 1'b1, last_stat));
    @(negedge clk);
    chk({tag, " start low"}, {31'd0, eng_start}, 32'd0);
    eng_finish(res);
    chk_stat({tag, " done"}, sbyte(1'b1, 1'b0, 1'b0, 1'b0, res));
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_stat("R1 status reset", 8'h80);
    rd(3'd1, v); chk("R1 cfg reset", {24'd0, v}, 32'h00);
    rd(3'd4, v); chk("R1 win lo reset", {24'd0, v}, 32'hFF);
    rd(3'd5, v); chk("R1 win hi reset", {24'd0, v}, 32'h00);
    chk("R1 start reset", {31'd0, eng_start}, 32'd0);
    chk("R1 irqs reset", {29'd0, irq_cc, irq_sgl, irq_dbl}, 32'd0);
  endtask

  task automatic t_launch;
    logic [7:0] v;
    run_ok("R3 R4 program", 8'h06, 8'h40, 2'b10);
    rd(3'd2, v); chk("R2 opcode reads 0", {24'd0, v}, 32'h00);
    rd(3'd3, v); chk("R2 taddr reads 0", {24'd0, v}, 32'h00);
    // busy-phase writes: read-only bits and staging
    stage(8'h01, 8'h22);
    wr(3'd0, 8'h80);
    chk("R3 start", {31'd0, eng_start}, 32'd1);
    @(negedge clk);
    wr(3'd0, 8'h0B);
    chk_stat("R10 ro bits", sbyte(1'b0, 1'b0, 1'b0, 1'b1, last_stat));
    wr(3'd2, 8'h06);
    chk_stat("R9 staging while busy", sbyte(1'b0, 1'b1, 1'b0, 1'b1, last_stat));
    chk("R9 opcode unchanged", {24'd0, eng_cmd}, 32'h01);
    eng_finish(2'b01);
    chk_stat("R4 result latched", sbyte(1'b1, 1'b1, 1'b0, 1'b0, 2'b01));
    wr(3'd0, 8'h20);
    chk_stat("R7 acc clear", sbyte(1'b1, 1'b0, 1'b0, 1'b0, last_stat));
  endtask

  task automatic t_illegal;
    stage(8'h55, 8'h10);
    wr(3'd0, 8'h80);
    chk("R5 no start", {31'd0, eng_start}, 32'd0);
    chk_stat("R5 acc set", sbyte(1'b0, 1'b1, 1'b0, 1'b0, last_stat));
    @(negedge clk);
    chk_stat("R5 ccif back", sbyte(1'b1, 1'b1, 1'b0, 1'b0, last_stat));
    stage(8'h06, 8'h11);
    wr(3'd0, 8'h80);
    chk("R8 acc blocks start", {31'd0, eng_start}, 32'd0);
    chk_stat("R8 acc blocks launch", sbyte(1'b1, 1'b1, 1'b0, 1'b0, last_stat));
    wr(3'd0, 8'h00);
    chk_stat("R7 write 0 keeps acc", sbyte(1'b1, 1'b1, 1'b0, 1'b0, last_stat));
    wr(3'd0, 8'hA0);
    chk("R8 clear+launch no start", {31'd0, eng_start}, 32'd0);
    chk_stat("R7 acc cleared", sbyte(1'b1, 1'b0, 1'b0, 1'b0, last_stat));
    wr(3'd2, 8'h77); wr(3'd0, 8'h80); @(negedge clk); wr(3'd0, 8'h20);
    wr(3'd2, 8'h08);
    chk("R5 next staging ok", {24'd0, eng_cmd}, 32'h08);
  endtask

  task automatic prot_hit(input string tag, input logic [7:0] op, input logic [7:0] ad);
    stage(op, ad);
    wr(3'd0, 8'h80);
    chk({tag, " no start"}, {31'd0, eng_start}, 32'd0);
    chk_stat({tag, " pv set"}, sbyte(1'b0, 1'b0, 1'b1, 1'b0, last_stat));
    @(negedge clk);
    chk_stat({tag, " ccif back"}, sbyte(1'b1, 1'b0, 1'b1, 1'b0, last_stat));
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wr(3'd4, 8'h10); wr(3'd5, 8'h20);
    rd(3'd4, v); chk("R2 win lo", {24'd0, v}, 32'h10);
    rd(3'd5, v); chk("R2 win hi", {24'd0, v}, 32'h20);
    prot_hit("R6 prog low edge", 8'h06, 8'h10);
    stage(8'h01, 8'h33);
    chk("R8 staging ignored in pv", {24'd0, eng_cmd}, 32'h06);
    chk("R8 taddr ignored in pv", {24'd0, eng_addr}, 32'h10);
    wr(3'd0, 8'h80);
    chk("R8 pv blocks start", {31'd0, eng_start}, 32'd0);
    wr(3'd0, 8'h00);
    chk_stat("R7 write 0 keeps pv", sbyte(1'b1, 1'b0, 1'b1, 1'b0, last_stat));
    wr(3'd0, 8'h10);
    chk_stat("R7 pv clear", sbyte(1'b1, 1'b0, 1'b0, 1'b0, last_stat));
    prot_hit("R6 serase high edge", 8'h0A, 8'h20);
    wr(3'd0, 8'h10);
    run_ok("R6 prog above", 8'h06, 8'h21, 2'b11);
    run_ok("R6 serase below", 8'h0A, 8'h0F, 2'b00);
    run_ok("R6 rdvfy inside", 8'h01, 8'h15, 2'b01);
    prot_hit("R6 merase window", 8'h08, 8'h00);
    wr(3'd0, 8'h10);
    wr(3'd4, 8'h30);
    run_ok("R6 merase empty window", 8'h08, 8'h00, 2'b10);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    sgl_fault = 1'b1; dbl_fault = 1'b1;
    #1;
    chk("R12 disabled", {30'd0, irq_sgl, irq_dbl}, 32'd0);
    chk("R11 disabled", {31'd0, irq_cc}, 32'd0);
    @(negedge clk);
    wr(3'd1, 8'h81);
    rd(3'd1, v); chk("R2 cfg read", {24'd0, v}, 32'h81);
    chk("R12 single only", {30'd0, irq_sgl, irq_dbl}, 32'd2);
    chk("R11 enabled", {31'd0, irq_cc}, 32'd1);
    wr(3'd1, 8'hFE);
    chk("R12 double only", {30'd0, irq_sgl, irq_dbl}, 32'd1);
    sgl_fault = 1'b0; dbl_fault = 1'b0;
    #1;
    chk("R12 fault low", {30'd0, irq_sgl, irq_dbl}, 32'd0);
    @(negedge clk);
    stage(8'h06, 8'h80);
    wr(3'd0, 8'h80);
    chk("R11 low while busy", {31'd0, irq_cc}, 32'd0);
    @(negedge clk);
    eng_finish(2'b00);
    chk("R11 high after done", {31'd0, irq_cc}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
    sgl_fault = 1'b0; dbl_fault = 1'b0; eng_done = 1'b0; eng_status = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_launch();
    t_illegal();
    t_protect();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule